// File: doc/BRIEF.md
# Windowed Block Address Generator

This block produces the block address sequence for one side (write or read) of a large frame buffer. The buffer is organised as 8192 blocks of 64 bytes. In sequential mode the block address climbs by one after every 64 advance strobes and wraps modulo 8192. In window mode it walks a rectangle. The rectangle is set by a start block, a row length in blocks and a row count. Successive rows begin one stride apart. A negative (two's complement) stride flips the picture vertically. An X-mirror option walks every row downward from its base. After the last block of the last row, the walk returns to the start block.

Settings are sampled only on a pointer reset pulse. Changes between pulses do not affect the walk in progress. A byte counter inside the block selects the byte within the current block. Each advance strobe also yields a write-suppress qualifier. In window mode the latched freeze setting drives it. In sequential mode the external hardware mask drives it. The pointer moves on every strobe either way.

The parameter `HAS_MIRROR` selects the side. When it is 1 (write side) the stride is signed and mirror and freeze are honoured. When it is 0 (read side) the stride is taken as unsigned without its top bit, and mirror and freeze are forced off.

Top module: `win_addr_gen`

## Requirements
- R1: After the synchronous reset `rst`, `blk_addr` is 0, `byte_ofs` is 0, `in_win` is 0, and `wr_suppress` is 0 while `adv` is low.
- R2: A `ptr_rst` pulse latches every `cfg_*` input. It sets `byte_ofs` to 0. It sets `blk_addr` to `cfg_start` when `cfg_win_en` is 1, and to 0 otherwise. `cfg_*` changes between pulses have no effect. When `ptr_rst` and `adv` are high in the same cycle, `ptr_rst` wins.
- R3: Each `adv` strobe increments `byte_ofs` (0 to 63). `blk_addr` steps only on the strobe that takes `byte_ofs` from 63 back to 0.
- R4: In sequential mode (latched enable 0), each block step adds 1 to `blk_addr`.
- R5: In window mode without X-mirror, column c of a row is at row base + c, for c from 0 to xsize-1.
- R6: In window mode with X-mirror, column c of a row is at row base - c.
- R7: After the last column of a row, the next row base is the previous base plus `cfg_stride`, read as 13-bit two's complement. A negative stride walks rows downward.
- R8: After the last column of row ysize-1, `blk_addr` returns to the latched start block and the walk repeats.
- R9: All block address arithmetic wraps modulo 8192 (for example 8191 + 1 = 0 and 0 - 1 = 8191).
- R10: An xsize or ysize of 0 behaves as a size of 1.
- R11: `in_win` is 1 after a `ptr_rst` that latched `cfg_win_en` = 1, and 0 after one that latched 0.
- R12: `wr_suppress` is 0 when `adv` is low. While `adv` is high it equals the latched freeze bit in window mode, and `hw_mask` in sequential mode. In both cases the pointer still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_rst | input | 1 | Pointer reset; latches settings |
| adv | input | 1 | Advance strobe, one byte per cycle |
| hw_mask | input | 1 | External write mask (sequential mode) |
| cfg_start | input | 13 | Window start block |
| cfg_xsize | input | 10 | Row length in blocks |
| cfg_stride | input | 13 | Row-to-row stride, two's complement |
| cfg_ysize | input | 16 | Number of rows |
| cfg_win_en | input | 1 | Window mode enable |
| cfg_xmir | input | 1 | X-mirror enable |
| cfg_freeze | input | 1 | Software freeze (window mode only) |
| blk_addr | output | 13 | Current block address |
| byte_ofs | output | 6 | Byte offset within the block |
| in_win | output | 1 | Window walk active |
| wr_suppress | output | 1 | Suppress the write of this strobe |

## Verification
The pointer reset and the advance strobe can land in the same cycle. The bench provokes this mid-block, after new settings have been presented. It expects the freshly latched start block and a zero byte offset, with no trace of the strobe. A second collision is the byte-counter wrap on the last column of the last row, where a row step and the return to start compete. The bench runs a window to exactly that step count and expects the start block, not the next stride.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int BLK_W_DEF = 13;
  localparam int XS_W_DEF  = 10;
  localparam int YS_W_DEF  = 16;
  localparam int OFS_W_DEF = 6;

  typedef enum logic {WALK_SEQ = 1'b0, WALK_WIN = 1'b1} walk_mode_e;
endpackage

// File: rtl/wag_cfg_latch.sv
module wag_cfg_latch #(
  parameter int BLK_W      = wag_pkg::BLK_W_DEF,
  parameter int XS_W       = wag_pkg::XS_W_DEF,
  parameter int YS_W       = wag_pkg::YS_W_DEF,
  parameter bit HAS_MIRROR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] cfg_start,
  input  logic [XS_W-1:0]  cfg_xsize,
  input  logic [BLK_W-1:0] cfg_stride,
  input  logic [YS_W-1:0]  cfg_ysize,
  input  logic             cfg_win_en,
  input  logic             cfg_xmir,
  input  logic             cfg_freeze,
  output logic [BLK_W-1:0] l_start,
  output logic [XS_W-1:0]  l_xsize,
  output logic [BLK_W-1:0] l_stride,
  output logic [YS_W-1:0]  l_ysize,
  output wag_pkg::walk_mode_e l_mode,
  output logic             l_xmir,
  output logic             l_freeze
);
  logic [BLK_W-1:0] stride_m;
  logic             xmir_m, frz_m;

  // Side variant: signed stride with mirror/freeze, or unsigned stride only.
  generate
    if (HAS_MIRROR) begin : g_wr_side
      assign stride_m = cfg_stride;
      assign xmir_m   = cfg_xmir;
      assign frz_m    = cfg_freeze;
    end else begin : g_rd_side
      assign stride_m = {1'b0, cfg_stride[BLK_W-2:0]};
      assign xmir_m   = 1'b0;
      assign frz_m    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      l_start  <= '0;
      l_xsize  <= '0;
      l_stride <= '0;
      l_ysize  <= '0;
      l_mode   <= wag_pkg::WALK_SEQ;
      l_xmir   <= 1'b0;
      l_freeze <= 1'b0;
    end else if (load) begin
      l_start  <= cfg_start;
      l_xsize  <= cfg_xsize;
      l_stride <= stride_m;
      l_ysize  <= cfg_ysize;
      l_mode   <= cfg_win_en ? wag_pkg::WALK_WIN : wag_pkg::WALK_SEQ;
      l_xmir   <= xmir_m;
      l_freeze <= frz_m;
    end
  end

  // R2: settings stay put between pointer resets
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(l_start) && $stable(l_stride) && $stable(l_xsize)
               && $stable(l_ysize) && $stable(l_mode)));
endmodule

// File: rtl/wag_byte_ctr.sv
module wag_byte_ctr #(
  parameter int OFS_W = wag_pkg::OFS_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [OFS_W-1:0] ofs,
  output logic             blk_step
);
  localparam logic [OFS_W-1:0] OFS_LAST = {OFS_W{1'b1}};

  assign blk_step = adv && !clr && (ofs == OFS_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) ofs <= '0;
    else if (adv)   ofs <= ofs + 1'b1;
  end

  // R3: one byte per strobe, wrapping at the block end
  a_r3_ofs_inc: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (ofs == OFS_W'($past(ofs) + 1'b1)));
  a_r3_ofs_idle: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(ofs));
endmodule

// File: rtl/wag_walker.sv
module wag_walker #(
  parameter int BLK_W = wag_pkg::BLK_W_DEF,
  parameter int XS_W  = wag_pkg::XS_W_DEF,
  parameter int YS_W  = wag_pkg::YS_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] load_start,
  input  logic             load_win,
  input  logic             step,
  input  logic [BLK_W-1:0] l_start,
  input  logic [XS_W-1:0]  l_xsize,
  input  logic [BLK_W-1:0] l_stride,
  input  logic [YS_W-1:0]  l_ysize,
  input  wag_pkg::walk_mode_e l_mode,
  input  logic             l_xmir,
  output logic [BLK_W-1:0] blk,
  output logic             in_win
);
  logic [XS_W-1:0]  col;
  logic [YS_W-1:0]  row;
  logic [BLK_W-1:0] base;
  logic             x_last, y_last;

  // A size of zero counts as one (col+1 >= size)
  assign x_last = ({1'b0, col} + 1'b1) >= {1'b0, l_xsize};
  assign y_last = ({1'b0, row} + 1'b1) >= {1'b0, l_ysize};

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      row    <= '0;
      base   <= '0;
      blk    <= '0;
      in_win <= 1'b0;
    end else if (load) begin
      col    <= '0;
      row    <= '0;
      base   <= load_start;
      blk    <= load_win ? load_start : '0;
      in_win <= load_win;
    end else if (step) begin
      if (l_mode == wag_pkg::WALK_SEQ) begin
        blk <= blk + 1'b1;
      end else if (!x_last) begin
        col <= col + 1'b1;
        blk <= l_xmir ? blk - 1'b1 : blk + 1'b1;
      end else if (y_last) begin
        col  <= '0;
        row  <= '0;
        base <= l_start;
        blk  <= l_start;
      end else begin
        col  <= '0;
        row  <= row + 1'b1;
        base <= base + l_stride;
        blk  <= base + l_stride;
      end
    end
  end

  // R3: the block address moves only on a block step or a reload
  a_r3_blk_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(blk));
  // R5 / R10: column index stays inside the row
  a_r5_col_range: assert property (@(posedge clk) disable iff (rst)
    (col == '0) || (col < l_xsize));
  // R8 / R10: row index stays inside the window
  a_r8_row_range: assert property (@(posedge clk) disable iff (rst)
    (row == '0) || (row < l_ysize));
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen #(
  parameter int BLK_W      = wag_pkg::BLK_W_DEF,
  parameter int XS_W       = wag_pkg::XS_W_DEF,
  parameter int YS_W       = wag_pkg::YS_W_DEF,
  parameter int OFS_W      = wag_pkg::OFS_W_DEF,
  parameter bit HAS_MIRROR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_rst,
  input  logic             adv,
  input  logic             hw_mask,
  input  logic [BLK_W-1:0] cfg_start,
  input  logic [XS_W-1:0]  cfg_xsize,
  input  logic [BLK_W-1:0] cfg_stride,
  input  logic [YS_W-1:0]  cfg_ysize,
  input  logic             cfg_win_en,
  input  logic             cfg_xmir,
  input  logic             cfg_freeze,
  output logic [BLK_W-1:0] blk_addr,
  output logic [OFS_W-1:0] byte_ofs,
  output logic             in_win,
  output logic             wr_suppress
);
  logic [BLK_W-1:0]    l_start, l_stride;
  logic [XS_W-1:0]     l_xsize;
  logic [YS_W-1:0]     l_ysize;
  wag_pkg::walk_mode_e l_mode;
  logic                l_xmir, l_freeze;
  logic                blk_step;

  wag_cfg_latch #(.BLK_W(BLK_W), .XS_W(XS_W), .YS_W(YS_W), .HAS_MIRROR(HAS_MIRROR)) u_latch (
    .clk(clk), .rst(rst), .load(ptr_rst),
    .cfg_start(cfg_start), .cfg_xsize(cfg_xsize), .cfg_stride(cfg_stride),
    .cfg_ysize(cfg_ysize), .cfg_win_en(cfg_win_en), .cfg_xmir(cfg_xmir),
    .cfg_freeze(cfg_freeze),
    .l_start(l_start), .l_xsize(l_xsize), .l_stride(l_stride), .l_ysize(l_ysize),
    .l_mode(l_mode), .l_xmir(l_xmir), .l_freeze(l_freeze)
  );

  wag_byte_ctr #(.OFS_W(OFS_W)) u_bytes (
    .clk(clk), .rst(rst), .clr(ptr_rst), .adv(adv),
    .ofs(byte_ofs), .blk_step(blk_step)
  );

  wag_walker #(.BLK_W(BLK_W), .XS_W(XS_W), .YS_W(YS_W)) u_walk (
    .clk(clk), .rst(rst), .load(ptr_rst), .load_start(cfg_start),
    .load_win(cfg_win_en), .step(blk_step),
    .l_start(l_start), .l_xsize(l_xsize), .l_stride(l_stride), .l_ysize(l_ysize),
    .l_mode(l_mode), .l_xmir(l_xmir), .blk(blk_addr), .in_win(in_win)
  );

  // Freeze replaces the hardware mask in window mode only.
  assign wr_suppress = adv && ((l_mode == wag_pkg::WALK_WIN) ? l_freeze : hw_mask);

  // R2: a pointer reset lands on the start block or zero
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    ptr_rst |=> (blk_addr == ($past(cfg_win_en) ? $past(cfg_start) : '0)) && (byte_ofs == '0));
  // R11: window flag follows the latched enable
  a_r11_flag: assert property (@(posedge clk) disable iff (rst)
    ptr_rst |=> (in_win == $past(cfg_win_en)));
  // R12: no suppression without a strobe
  a_r12_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |-> !wr_suppress);
endmodule

// File: tb/win_addr_gen_bench.sv
module win_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst, ptr_rst, adv, hw_mask;
  logic [12:0] cfg_start, cfg_stride;
  logic [9:0]  cfg_xsize;
  logic [15:0] cfg_ysize;
  logic        cfg_win_en, cfg_xmir, cfg_freeze;
  logic [12:0] blk_addr;
  logic [5:0]  byte_ofs;
  logic        in_win, wr_suppress;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  win_addr_gen u_win_addr_gen (
    .clk(clk), .rst(rst), .ptr_rst(ptr_rst), .adv(adv), .hw_mask(hw_mask),
    .cfg_start(cfg_start), .cfg_xsize(cfg_xsize), .cfg_stride(cfg_stride),
    .cfg_ysize(cfg_ysize), .cfg_win_en(cfg_win_en), .cfg_xmir(cfg_xmir),
    .cfg_freeze(cfg_freeze), .blk_addr(blk_addr), .byte_ofs(byte_ofs),
    .in_win(in_win), .wr_suppress(wr_suppress)
  );

  // Vector table: start, xsize, stride, ysize, xmir, win, block steps, expected block
  localparam int NV = 12;
  localparam int V_START [NV] = '{0,   100, 100, 100, 100, 100, 100, 100,  8190, 1,    50, 50};
  localparam int V_XS    [NV] = '{4,   4,   4,   4,   4,   4,   4,   4,    4,    4,    0,  0};
  localparam int V_STR   [NV] = '{10,  10,  10,  10,  10,  10,  10,  8182, 0,    0,    5,  5};
  localparam int V_YS    [NV] = '{3,   3,   3,   3,   3,   3,   3,   3,    1,    1,    3,  3};
  localparam int V_XMIR  [NV] = '{0,   0,   0,   0,   0,   1,   1,   0,    0,    1,    0,  0};
  localparam int V_WIN   [NV] = '{0,   1,   1,   1,   1,   1,   1,   1,    1,    1,    1,  1};
  localparam int V_N     [NV] = '{5,   2,   4,   7,   12,  3,   5,   9,    3,    2,    1,  3};
  localparam int V_EXP   [NV] = '{5,   102, 110, 113, 100, 97,  109, 81,   1,    8191, 55, 50};
  localparam string V_TAG [NV] = '{"R4", "R5", "R7", "R5", "R8", "R6", "R6", "R7",
                                   "R9", "R9", "R10", "R10"};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_ptr();
    ptr_rst = 1'b1;
    @(negedge clk);
    ptr_rst = 1'b0;
  endtask

  task automatic run_adv(input int n);
    adv = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic set_cfg(input int st, input int xs, input int sd, input int ys,
                         input bit xm, input bit we, input bit fz);
    cfg_start = 13'(st); cfg_xsize = 10'(xs); cfg_stride = 13'(sd);
    cfg_ysize = 16'(ys); cfg_xmir = xm; cfg_win_en = we; cfg_freeze = fz;
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ptr_rst = 1'b0; adv = 1'b0; hw_mask = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 blk", blk_addr, 0);
    chk("R1 ofs", byte_ofs, 0);
    chk("R1 in_win", in_win, 0);
    chk("R1 wr_suppress", wr_suppress, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      set_cfg(V_START[v], V_XS[v], V_STR[v], V_YS[v], V_XMIR[v][0], V_WIN[v][0], 1'b0);
      pulse_ptr();
      run_adv(V_N[v] * 64);
      chk(V_TAG[v], blk_addr, V_EXP[v]);
      chk("R11 in_win", in_win, V_WIN[v]);
    end

    // R3 byte offset and block step boundary (sequential mode)
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    pulse_ptr();
    run_adv(63);
    chk("R3 blk before wrap", blk_addr, 0);
    chk("R3 ofs at 63", byte_ofs, 63);
    run_adv(1);
    chk("R3 blk after wrap", blk_addr, 1);
    chk("R3 ofs wrapped", byte_ofs, 0);

    // R2 settings ignored until the next pointer reset
    set_cfg(100, 4, 10, 3, 0, 1, 0);
    pulse_ptr();
    set_cfg(500, 2, 7, 1, 1, 0, 0);
    run_adv(64);
    chk("R2 cfg ignored", blk_addr, 101);
    chk("R2 cfg ignored in_win", in_win, 1);

    // R2 pointer reset wins over a simultaneous strobe
    run_adv(10);
    set_cfg(200, 4, 10, 3, 0, 1, 0);
    ptr_rst = 1'b1; adv = 1'b1;
    @(negedge clk);
    ptr_rst = 1'b0; adv = 1'b0;
    chk("R2 priority blk", blk_addr, 200);
    chk("R2 priority ofs", byte_ofs, 0);

    // R12 freeze in window mode, hardware mask ignored there
    set_cfg(300, 4, 10, 3, 0, 1, 1);
    pulse_ptr();
    hw_mask = 1'b0; adv = 1'b1; #1;
    chk("R12 freeze window", wr_suppress, 1);
    @(negedge clk);
    adv = 1'b0;
    chk("R12 frozen still advances", byte_ofs, 1);
    set_cfg(300, 4, 10, 3, 0, 1, 0);
    pulse_ptr();
    hw_mask = 1'b1; adv = 1'b1; #1;
    chk("R12 hw mask ignored window", wr_suppress, 0);
    @(negedge clk);
    adv = 1'b0;

    // R12 sequential mode: freeze ignored, hardware mask applies
    set_cfg(0, 0, 0, 0, 0, 0, 1);
    pulse_ptr();
    hw_mask = 1'b0; adv = 1'b1; #1;
    chk("R12 freeze ignored seq", wr_suppress, 0);
    hw_mask = 1'b1; #1;
    chk("R12 hw mask seq", wr_suppress, 1);
    @(negedge clk);
    adv = 1'b0; #1;
    chk("R12 idle", wr_suppress, 0);
    chk("R12 masked still advances", byte_ofs, 1);
    hw_mask = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule